// File: doc/BRIEF.md
# Instruction Byte Prefetch Queue

This block sits between a byte-wide code memory and an instruction consumer. It keeps a small buffer of up to six instruction bytes filled ahead of use, so that the consumer normally finds its next byte already waiting instead of stalling on memory. Fetching goes on in parallel with consumption: whenever a slot is free, counting a fetch that is already in progress, a new read request goes out.

The fetch position is a 16-bit code segment and a 16-bit offset. The 20-bit physical address is the segment shifted left by four bit positions plus the offset. Each byte returned by memory advances the offset by one. The offset wraps within its 16 bits, so fetching never carries into the segment. A redirect input drops everything buffered or arriving and restarts fetching from a new segment and offset. This is used for jumps and any other change of control flow.

Top module: `prefetch_queue`

## Requirements
- R1: The queue holds at most 6 bytes; `qLevel` never exceeds 6 and a full queue keeps its contents until a pop.
- R2: `memAddr` equals ({segment, 4'b0000} + {4'b0000, offset}) truncated to 20 bits, where segment and offset are the current fetch segment and offset.
- R3: `memReq` is high only when `qLevel` is below 6, so the queue plus one outstanding fetch never exceeds 6 bytes; a pop from a full queue makes `memReq` rise in the next cycle.
- R4: Once raised, `memReq` stays high with `memAddr` unchanged until a cycle with `memAck` high or a redirect.
- R5: A cycle with `memReq` and `memAck` both high appends `memData` at the tail and advances the offset by one, wrapping from 16'hFFFF to 16'h0000 without changing the segment.
- R6: `byteOut` shows the oldest buffered byte and `byteValid` is high exactly when `qLevel` is nonzero; a cycle with `popReq` and `byteValid` high removes that byte, and bytes leave in the order they arrived.
- R7: `popReq` while the queue is empty is ignored: `qLevel` stays 0 and no byte is lost or skipped.
- R8: A cycle with `flushReq` high empties the queue, drops `memReq`, discards a byte acknowledged in that same cycle, and loads `flushSeg` and `flushOff` as the fetch segment and offset; `memReq` rises again in the following cycle at the new address.
- R9: A pop and an accepted fetch byte in the same cycle both take effect, leaving `qLevel` unchanged.
- R10: After an accepted byte, if a slot remains free, `memReq` stays high in the next cycle at the next address, so a zero-wait memory fills an empty queue in six consecutive cycles.
- R11: While `rstN` is low the queue is empty, `memReq` is low, and the fetch position is segment 16'hFFFF, offset 16'h0000 (address 20'hFFFF0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| flushReq | input | 1 | Redirect: empty the queue and load a new fetch position |
| flushSeg | input | 16 | Code segment loaded on redirect |
| flushOff | input | 16 | Offset loaded on redirect |
| memReq | output | 1 | Code memory read request |
| memAddr | output | 20 | Physical fetch address |
| memAck | input | 1 | Memory acknowledge; `memData` is valid in the same cycle |
| memData | input | 8 | Byte returned by memory |
| popReq | input | 1 | Consumer takes the head byte |
| byteValid | output | 1 | Queue holds at least one byte |
| byteOut | output | 8 | Oldest buffered byte |
| qLevel | output | 3 | Number of buffered bytes |

## Verification
The hardest case to reach from the ports is a memory acknowledge that lands in the same cycle as a redirect. An automatic memory model cannot line the two up reliably. For these scenarios the bench therefore switches the model off and drives `memAck`, `memData` and `flushReq` together by hand on one falling edge. It then confirms that the discarded byte never appears: the next byte fetched from the new address must be the head. A pop that coincides with an accepted byte is reached the same way, and offset wrap is reached by redirecting to offset 16'hFFFE.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

  // Strobes issued by the control unit to the datapath each cycle.
  typedef struct packed {
    logic load;   // redirect: clear queue, load new segment/offset
    logic write;  // append returned byte, advance offset
    logic pop;    // remove head byte
  } pfqStrobe_t;

endpackage

// File: rtl/pfq_addr_gen.sv
module pfq_addr_gen #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int ADDR_W = 20,
  parameter int SHIFT  = 4
) (
  input  logic [SEG_W-1:0]  codeSeg,
  input  logic [OFF_W-1:0]  fetchOff,
  output logic [ADDR_W-1:0] physAddr
);

  logic [ADDR_W-1:0] segBase;
  logic [ADDR_W-1:0] offExt;

  // Widen both operands to the address width; excess carry is dropped.
  always_comb begin
    segBase  = ADDR_W'(codeSeg) << SHIFT;
    offExt   = ADDR_W'(fetchOff);
    physAddr = segBase + offExt;
  end

endmodule

// File: rtl/pfq_ctrl.sv
module pfq_ctrl
  import pfq_pkg::*;
#(
  parameter int DEPTH = 6,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flushReq,
  input  logic             memAck,
  input  logic             popReq,
  input  logic [CNT_W-1:0] level,
  output logic             memReq,
  output pfqStrobe_t       strobe
);

  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

  logic             reqActive;
  logic             reqNext;
  logic [CNT_W-1:0] nextLevel;
  logic             queueEmpty;

  assign queueEmpty = (level == '0);
  assign memReq     = reqActive;

  // Strobe generation: redirect overrides both write and pop.
  always_comb begin
    strobe       = '0;
    strobe.load  = flushReq;
    strobe.write = reqActive && memAck && !flushReq;
    strobe.pop   = popReq && !queueEmpty && !flushReq;
  end

  // Occupancy after this cycle's write and pop, used to decide whether
  // the next request may go out without overfilling the queue.
  always_comb begin
    nextLevel = level + CNT_W'(strobe.write) - CNT_W'(strobe.pop);
  end

  always_comb begin
    if (flushReq) begin
      reqNext = 1'b0;
    end else if (reqActive && !memAck) begin
      reqNext = 1'b1;
    end else begin
      reqNext = (nextLevel < FULL_LVL);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqActive <= 1'b0;
    end else begin
      reqActive <= reqNext;
    end
  end

  AST_REQ_SPACE: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (level < FULL_LVL)); // R3

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && !flushReq) |=> memReq); // R4

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> (!memReq && level == '0)); // R8

  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rstN)
    (queueEmpty && !(memReq && memAck)) |=> (level == '0)); // R7

  AST_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck && popReq && !queueEmpty && !flushReq)
      |=> (level == $past(level))); // R9

endmodule

// File: rtl/pfq_datapath.sv
module pfq_datapath
  import pfq_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int DATA_W = 8,
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter logic [SEG_W-1:0] RESET_SEG = '1,
  parameter logic [OFF_W-1:0] RESET_OFF = '0,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  pfqStrobe_t        strobe,
  input  logic [SEG_W-1:0]  flushSeg,
  input  logic [OFF_W-1:0]  flushOff,
  input  logic [DATA_W-1:0] memData,
  output logic [SEG_W-1:0]  codeSeg,
  output logic [OFF_W-1:0]  fetchOff,
  output logic [CNT_W-1:0]  level,
  output logic [DATA_W-1:0] headByte
);

  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_LVL  = CNT_W'(DEPTH);

  logic [DATA_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [PTR_W-1:0]  wrPtrInc;
  logic [PTR_W-1:0]  rdPtrInc;

  // Circular pointers wrap at DEPTH, which need not be a power of two.
  always_comb begin
    wrPtrInc = (wrPtr == LAST_SLOT) ? '0 : wrPtr + 1'b1;
    rdPtrInc = (rdPtr == LAST_SLOT) ? '0 : rdPtr + 1'b1;
  end

  // Fetch position: redirect loads, accepted byte advances the offset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeSeg  <= RESET_SEG;
      fetchOff <= RESET_OFF;
    end else if (strobe.load) begin
      codeSeg  <= flushSeg;
      fetchOff <= flushOff;
    end else if (strobe.write) begin
      fetchOff <= fetchOff + 1'b1;
    end
  end

  // Pointer and occupancy bookkeeping.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (strobe.load) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (strobe.write) begin
        wrPtr <= wrPtrInc;
      end
      if (strobe.pop) begin
        rdPtr <= rdPtrInc;
      end
      level <= level + CNT_W'(strobe.write) - CNT_W'(strobe.pop);
    end
  end

  // Byte storage, one enable per slot.
  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobe.write && (wrPtr == PTR_W'(s))) begin
        slots[s] <= memData;
      end
    end
  end

  assign headByte = slots[rdPtr];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    level <= FULL_LVL); // R1

  AST_OFF_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.write && !strobe.load) |=> (fetchOff == $past(fetchOff) + 1'b1)); // R5

  AST_SEG_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(codeSeg)); // R5

endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
  import pfq_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int DATA_W = 8,
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int ADDR_W = 20,
  parameter int SHIFT  = 4,
  parameter logic [SEG_W-1:0] RESET_SEG = '1,
  parameter logic [OFF_W-1:0] RESET_OFF = '0,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flushReq,
  input  logic [SEG_W-1:0]  flushSeg,
  input  logic [OFF_W-1:0]  flushOff,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memData,
  input  logic              popReq,
  output logic              byteValid,
  output logic [DATA_W-1:0] byteOut,
  output logic [CNT_W-1:0]  qLevel
);

  pfqStrobe_t       strobe;
  logic [SEG_W-1:0] codeSeg;
  logic [OFF_W-1:0] fetchOff;
  logic [CNT_W-1:0] level;

  pfq_ctrl #(
    .DEPTH (DEPTH)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .flushReq (flushReq),
    .memAck   (memAck),
    .popReq   (popReq),
    .level    (level),
    .memReq   (memReq),
    .strobe   (strobe)
  );

  pfq_datapath #(
    .DEPTH     (DEPTH),
    .DATA_W    (DATA_W),
    .SEG_W     (SEG_W),
    .OFF_W     (OFF_W),
    .RESET_SEG (RESET_SEG),
    .RESET_OFF (RESET_OFF)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .flushSeg (flushSeg),
    .flushOff (flushOff),
    .memData  (memData),
    .codeSeg  (codeSeg),
    .fetchOff (fetchOff),
    .level    (level),
    .headByte (byteOut)
  );

  pfq_addr_gen #(
    .SEG_W  (SEG_W),
    .OFF_W  (OFF_W),
    .ADDR_W (ADDR_W),
    .SHIFT  (SHIFT)
  ) i_addr_gen (
    .codeSeg  (codeSeg),
    .fetchOff (fetchOff),
    .physAddr (memAddr)
  );

  assign byteValid = (level != '0);
  assign qLevel    = level;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && !flushReq) |=> $stable(memAddr)); // R4

endmodule

// File: tb/test_prefetch_queue.sv
module test_prefetch_queue;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flushReq = 1'b0;
  logic [15:0] flushSeg = '0;
  logic [15:0] flushOff = '0;
  logic        memReq;
  logic [19:0] memAddr;
  logic        memAck;
  logic [7:0]  memData;
  logic        popReq = 1'b0;
  logic        byteValid;
  logic [7:0]  byteOut;
  logic [2:0]  qLevel;

  logic        autoAck = 1'b0;
  logic [7:0]  autoData = '0;
  logic        manAck = 1'b0;
  logic [7:0]  manData = '0;
  logic        memAuto = 1'b0;
  int          memLat = 0;
  int          waitCnt = 0;

  int chkCnt = 0;
  int errCnt = 0;

  assign memAck  = autoAck | manAck;
  assign memData = autoAck ? autoData : manData;

  always #(CLK_PERIOD / 2) clk = ~clk;

  prefetch_queue i_prefetch_queue (
    .clk       (clk),
    .rstN      (rstN),
    .flushReq  (flushReq),
    .flushSeg  (flushSeg),
    .flushOff  (flushOff),
    .memReq    (memReq),
    .memAddr   (memAddr),
    .memAck    (memAck),
    .memData   (memData),
    .popReq    (popReq),
    .byteValid (byteValid),
    .byteOut   (byteOut),
    .qLevel    (qLevel)
  );

  function automatic logic [7:0] romByte(input logic [19:0] a);
    return a[7:0] ^ a[19:12];
  endfunction

  function automatic logic [19:0] physOf(input logic [15:0] seg, input logic [15:0] off);
    return {seg, 4'h0} + {4'h0, off};
  endfunction

  // Memory model: acknowledges after memLat waiting cycles.
  always @(negedge clk) begin
    if (memAuto && rstN && memReq) begin
      if (waitCnt >= memLat) begin
        autoAck  = 1'b1;
        autoData = romByte(memAddr);
        waitCnt  = 0;
      end else begin
        autoAck = 1'b0;
        waitCnt++;
      end
    end else begin
      autoAck = 1'b0;
      waitCnt = 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic redirect(input logic [15:0] seg, input logic [15:0] off);
    @(negedge clk);
    flushReq = 1'b1;
    flushSeg = seg;
    flushOff = off;
    @(negedge clk);
    flushReq = 1'b0;
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    chk("R11 memReq in reset", memReq, 0);
    chk("R11 byteValid in reset", byteValid, 0);
    chk("R11 qLevel in reset", qLevel, 0);
    chk("R11 R2 reset address", memAddr, 20'hFFFF0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11 request after reset", memReq, 1);
  endtask

  task automatic test_addr();
    memAuto = 1'b0;
    @(negedge clk);
    redirect(16'h1234, 16'h5678);
    chk("R8 memReq low after redirect", memReq, 0);
    chk("R8 qLevel after redirect", qLevel, 0);
    @(negedge clk);
    chk("R8 memReq resumes", memReq, 1);
    chk("R2 address 1234:5678", memAddr, 20'h179B8);
    redirect(16'hFFFF, 16'h0020);
    @(negedge clk);
    chk("R2 address truncation FFFF:0020", memAddr, 20'h00010);
  endtask

  task automatic test_stream();
    memLat  = 0;
    memAuto = 1'b1;
    redirect(16'h2000, 16'h0010);
    repeat (6) @(negedge clk);
    chk("R10 level after six cycles", qLevel, 5);
    chk("R10 request still high", memReq, 1);
    @(negedge clk);
    chk("R1 full level", qLevel, 6);
    chk("R3 no request when full", memReq, 0);
    repeat (3) @(negedge clk);
    chk("R1 stays full", qLevel, 6);
    popReq = 1'b1;
    for (int i = 0; i < 10; i++) begin
      chk("R6 byteValid while streaming", byteValid, 1);
      chk("R6 stream order", byteOut, romByte(physOf(16'h2000, 16'h0010 + 16'(i))));
      if (i == 1) chk("R3 request after pop from full", memReq, 1);
      @(negedge clk);
    end
    popReq = 1'b0;
  endtask

  task automatic test_wrap();
    memLat  = 1;
    memAuto = 1'b1;
    redirect(16'h0100, 16'hFFFE);
    repeat (16) @(negedge clk);
    memAuto = 1'b0;
    chk("R1 wrap fill level", qLevel, 6);
    popReq = 1'b1;
    for (int i = 0; i < 6; i++) begin
      logic [15:0] o;
      o = 16'hFFFE + 16'(i);
      chk("R5 offset wraps within segment", byteOut, romByte(physOf(16'h0100, o)));
      @(negedge clk);
    end
    popReq = 1'b0;
    chk("R6 empty after popping all", byteValid, 0);
  endtask

  task automatic test_pop_empty();
    memAuto = 1'b0;
    @(negedge clk);
    redirect(16'h3000, 16'h0000);
    popReq = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk("R7 pop on empty keeps level", qLevel, 0);
      chk("R7 pop on empty keeps byteValid low", byteValid, 0);
    end
    popReq = 1'b0;
    memLat  = 0;
    memAuto = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 first byte not skipped", byteOut, romByte(20'h30000));
    memAuto = 1'b0;
    @(negedge clk);
  endtask

  task automatic test_hold_overlap_flush();
    redirect(16'h0040, 16'h0100);
    @(negedge clk);
    chk("R2 address 0040:0100", memAddr, 20'h00500);
    repeat (5) begin
      @(negedge clk);
      chk("R4 request held", memReq, 1);
      chk("R4 address held", memAddr, 20'h00500);
    end
    manAck = 1'b1; manData = 8'h5A;
    @(negedge clk);
    manAck = 1'b0;
    chk("R5 byte appended", byteOut, 8'h5A);
    chk("R5 level after ack", qLevel, 1);
    chk("R5 address advanced", memAddr, 20'h00501);
    chk("R10 request continues", memReq, 1);
    manAck = 1'b1; manData = 8'h5B;
    @(negedge clk);
    manData = 8'h5C;
    @(negedge clk);
    manAck = 1'b0;
    chk("R6 level three", qLevel, 3);
    manAck = 1'b1; manData = 8'h77; popReq = 1'b1;
    @(negedge clk);
    manAck = 1'b0; popReq = 1'b0;
    chk("R9 level unchanged on pop plus ack", qLevel, 3);
    chk("R9 head advanced", byteOut, 8'h5B);
    popReq = 1'b1;
    @(negedge clk);
    chk("R6 order 5C", byteOut, 8'h5C);
    @(negedge clk);
    chk("R6 order 77", byteOut, 8'h77);
    popReq = 1'b0;
    // redirect and acknowledge in the same cycle
    manAck = 1'b1; manData = 8'hEE;
    flushReq = 1'b1; flushSeg = 16'h0500; flushOff = 16'h0007;
    @(negedge clk);
    manAck = 1'b0; flushReq = 1'b0;
    chk("R8 queue emptied", qLevel, 0);
    chk("R8 byteValid low", byteValid, 0);
    chk("R8 request withdrawn", memReq, 0);
    @(negedge clk);
    chk("R8 request at new address", memReq, 1);
    chk("R8 new address", memAddr, 20'h05007);
    manAck = 1'b1; manData = 8'h11;
    @(negedge clk);
    manAck = 1'b0;
    chk("R8 in-flight byte discarded", byteOut, 8'h11);
    chk("R8 single byte after redirect", qLevel, 1);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    chkCnt++;
    errCnt++;
    $display("FAIL watchdog R1..all actual=timeout expected=completion");
    $display("%0d/%0d checks passed", chkCnt - errCnt, chkCnt);
    $finish;
  end

  initial begin
    test_reset();
    test_addr();
    test_stream();
    test_wrap();
    test_pop_empty();
    test_hold_overlap_flush();
    $display("%0d/%0d checks passed", chkCnt - errCnt, chkCnt);
    $finish;
  end

endmodule